// File: doc/BRIEF.md
# Transfer Residue Tracker

This block reports how many bytes of a multi-segment DMA descriptor are still outstanding. Software or a descriptor loader fills a small table in which each segment has a start address and a byte length. The loader then arms the descriptor with a segment count and a flag that selects a linear list or a cyclic ring. While the transfer runs, the engine reports three things: how many segments it has programmed, when a programmed batch completes, and when the whole descriptor completes.

A residue query carries the engine's live address pointer. In linear mode the block answers lazily. It keeps a committed residue and an accounted segment index, and walks forward from the accounted index towards the programmed index at one segment per clock. Every segment whose address range does not hold the pointer is retired from the residue. When the walk finds the segment that holds the pointer, it subtracts the offset into that segment. In cyclic mode the answer is the ring total minus the pointer's distance from the first segment's start.

Queries and answers are valid/ready streams. `q_ready` is high only while no query is in flight, so a query is held off from the cycle it is accepted until its answer has been taken. An answer stays on `res_bytes` with `res_valid` high until `res_ready` is seen high at a clock edge. All other pins are plain single-cycle pulses or levels.

Top module: `transfer_residue_tracker`

## Requirements
- R1: After reset `q_ready` is 1 and `res_valid` is 0, and at every point the accounted segment index never exceeds the programmed segment count.
- R2: Arming with N segments sets the residue to the sum of the lengths in table entries 0..N-1, and a linear query made before any segment is programmed returns that sum.
- R3: In linear mode, when the live pointer P satisfies start <= P < start+length for the segment at the accounted index, the answer is the committed residue minus (P - start), and the walk stops there.
- R4: Each segment that the walk passes without a range match has its length subtracted from the committed residue, and the accounted index advances past it for good, so a later query with the same pointer returns the same answer without walking those segments again.
- R5: If the walk reaches the programmed count without a range match, the answer is the committed residue unchanged.
- R6: An intermediate-completion pulse subtracts the byte sum of the most recently programmed batch from the residue, copies the result into the committed residue, and sets the accounted index to the programmed count.
- R7: A final-completion pulse on a linear descriptor forces the residue to zero, so any later query returns 0.
- R8: In cyclic mode the answer is the armed total minus (P - start of segment 0); intermediate and final completion pulses leave that total unchanged.
- R9: `q_ready` stays 0 from the acceptance of a query until its answer is taken, and while `res_valid` is 1 and `res_ready` is 0, `res_bytes` holds its value.
- R10: A completion pulse that arrives while a walk is in progress takes priority over that cycle's walk step, and the walk then continues from the new accounted index and committed residue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment table write strobe |
| seg_idx | input | IW | Table entry to write; entries at or above MAX_SEG are ignored |
| seg_addr | input | AW | Segment start address |
| seg_len | input | LW | Segment length in bytes |
| arm | input | 1 | Pulse: start tracking a new descriptor |
| arm_nseg | input | IW | Number of segments in the descriptor (clamped to MAX_SEG) |
| arm_cyclic | input | 1 | 1 selects ring mode, 0 selects linear list |
| prog | input | 1 | Pulse: the engine has programmed another batch |
| prog_cnt | input | IW | Segments in that batch (total is clamped to the armed count) |
| mid_done | input | 1 | Pulse: a programmed batch has completed |
| fin_done | input | 1 | Pulse: the whole descriptor has completed |
| live_pos | input | AW | Engine's current address pointer |
| q_valid | input | 1 | Residue query request |
| q_ready | output | 1 | Query accepted when high together with q_valid |
| res_valid | output | 1 | Answer available |
| res_ready | input | 1 | Consumer takes the answer |
| res_bytes | output | RW | Remaining byte count |

## Verification
The collision that matters is a completion pulse that arrives in the same cycle as a step of the lazy walk. Both want to write the accounted index and the committed residue. The bench accepts a query whose pointer lies past every programmed segment, so the walk has several segments to cover. It raises `mid_done` on the very next edge, while the walk is at its first step. The scoreboard then expects the answer computed from the completion's residue and index and not from the half-finished walk. Back-pressure is exercised by holding `res_ready` low and checking that the answer stays put and that no new query is taken in the meantime.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_WALK = 2'd1,
    WS_DONE = 2'd2
  } walk_state_e;
endpackage

// File: rtl/rt_seg_table.sv
module rt_seg_table #(
  parameter int MAX_SEG = 20,
  parameter int AW      = 32,
  parameter int LW      = 20,
  parameter int IW      = 5,
  parameter int RW      = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] waddr,
  input  logic [LW-1:0] wlen,
  input  logic [IW-1:0] ridx,
  output logic [AW-1:0] raddr,
  output logic [LW-1:0] rlen,
  output logic [AW-1:0] base_addr,
  input  logic [IW-1:0] tot_n,
  output logic [RW-1:0] tot_sum,
  input  logic [IW-1:0] bat_lo,
  input  logic [IW-1:0] bat_hi,
  output logic [RW-1:0] bat_sum
);
  logic [AW-1:0] addr_q [MAX_SEG];
  logic [LW-1:0] len_q  [MAX_SEG];
  logic [RW-1:0] tot_acc [MAX_SEG+1];
  logic [RW-1:0] bat_acc [MAX_SEG+1];

  assign tot_acc[0] = '0;
  assign bat_acc[0] = '0;

  for (genvar g = 0; g < MAX_SEG; g++) begin : g_ent
    logic in_tot;
    logic in_bat;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        len_q[g]  <= '0;
      end else if (we && widx == IW'(g)) begin
        addr_q[g] <= waddr;
        len_q[g]  <= wlen;
      end
    end

    assign in_tot = IW'(g) < tot_n;
    assign in_bat = (IW'(g) >= bat_lo) && (IW'(g) < bat_hi);
    assign tot_acc[g+1] = tot_acc[g] + (in_tot ? RW'(len_q[g]) : '0);
    assign bat_acc[g+1] = bat_acc[g] + (in_bat ? RW'(len_q[g]) : '0);
  end

  assign tot_sum   = tot_acc[MAX_SEG];
  assign bat_sum   = bat_acc[MAX_SEG];
  assign base_addr = addr_q[0];

  always_comb begin
    raddr = '0;
    rlen  = '0;
    for (int i = 0; i < MAX_SEG; i++) begin
      if (ridx == IW'(i)) begin
        raddr = addr_q[i];
        rlen  = len_q[i];
      end
    end
  end
endmodule

// File: rtl/rt_acct.sv
module rt_acct #(
  parameter int MAX_SEG = 20,
  parameter int LW      = 20,
  parameter int IW      = 5,
  parameter int RW      = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [IW-1:0] arm_nseg,
  input  logic          arm_cyc,
  input  logic [RW-1:0] arm_total,
  input  logic          prog,
  input  logic [IW-1:0] prog_cnt,
  input  logic [RW-1:0] bat_sum,
  input  logic          mid,
  input  logic          fin,
  input  logic          step,
  input  logic [LW-1:0] step_len,
  output logic          cyc,
  output logic [IW-1:0] proc,
  output logic [IW-1:0] prog_hi,
  output logic [IW-1:0] acct,
  output logic [RW-1:0] resid,
  output logic [RW-1:0] stat
);
  localparam logic [IW:0] MAXW = (IW+1)'(MAX_SEG);

  logic [IW-1:0] nseg_q;
  logic [RW-1:0] batch_q;
  logic [IW:0]   hi_raw;
  logic [IW-1:0] nseg_in;
  logic [RW-1:0] resid_mid;

  assign nseg_in   = ({1'b0, arm_nseg} > MAXW) ? IW'(MAX_SEG) : arm_nseg;
  assign hi_raw    = {1'b0, proc} + {1'b0, prog_cnt};
  assign prog_hi   = (hi_raw > {1'b0, nseg_q}) ? nseg_q : hi_raw[IW-1:0];
  assign resid_mid = resid - batch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc     <= 1'b0;
      nseg_q  <= '0;
      proc    <= '0;
      acct    <= '0;
      resid   <= '0;
      stat    <= '0;
      batch_q <= '0;
    end else if (arm) begin
      cyc     <= arm_cyc;
      nseg_q  <= nseg_in;
      proc    <= '0;
      acct    <= '0;
      resid   <= arm_total;
      stat    <= arm_total;
      batch_q <= '0;
    end else begin
      if (prog && !cyc) begin
        proc    <= prog_hi;
        batch_q <= bat_sum;
      end
      if (fin && !cyc) begin
        resid <= '0;
        stat  <= '0;
        acct  <= proc;
      end else if (mid && !cyc) begin
        resid <= resid_mid;
        stat  <= resid_mid;
        acct  <= proc;
      end else if (step) begin
        stat <= stat - RW'(step_len);
        acct <= acct + IW'(1);
      end
    end
  end
endmodule

// File: rtl/rt_walker.sv
module rt_walker
  import rt_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 20,
  parameter int IW = 5,
  parameter int RW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_valid,
  output logic          q_ready,
  input  logic [AW-1:0] live_pos,
  input  logic          cyc,
  input  logic [IW-1:0] acct,
  input  logic [IW-1:0] proc,
  input  logic [RW-1:0] stat,
  input  logic [RW-1:0] resid,
  input  logic [AW-1:0] seg_addr,
  input  logic [LW-1:0] seg_len,
  input  logic [AW-1:0] base_addr,
  output logic          step,
  output logic [LW-1:0] step_len,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [RW-1:0] res_bytes
);
  walk_state_e   st_q;
  logic [AW-1:0] pos_q;
  logic [AW:0]   end_ext;
  logic          hit;
  logic          at_end;
  logic [RW-1:0] off;
  logic [RW-1:0] ring_off;

  assign end_ext  = {1'b0, seg_addr} + (AW+1)'(seg_len);
  assign hit      = ({1'b0, pos_q} >= {1'b0, seg_addr}) && ({1'b0, pos_q} < end_ext);
  assign at_end   = (acct == proc);
  assign off      = RW'(pos_q - seg_addr);
  assign ring_off = RW'(live_pos - base_addr);

  assign q_ready   = (st_q == WS_IDLE);
  assign res_valid = (st_q == WS_DONE);
  assign step      = (st_q == WS_WALK) && !at_end && !hit;
  assign step_len  = seg_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= WS_IDLE;
      pos_q     <= '0;
      res_bytes <= '0;
    end else begin
      unique case (st_q)
        WS_IDLE: if (q_valid) begin
          if (cyc) begin
            res_bytes <= resid - ring_off;
            st_q      <= WS_DONE;
          end else begin
            pos_q <= live_pos;
            st_q  <= WS_WALK;
          end
        end
        WS_WALK: begin
          if (at_end) begin
            res_bytes <= stat;
            st_q      <= WS_DONE;
          end else if (hit) begin
            res_bytes <= stat - off;
            st_q      <= WS_DONE;
          end
        end
        WS_DONE: if (res_ready) st_q <= WS_IDLE;
        default: st_q <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/transfer_residue_tracker.sv
module transfer_residue_tracker #(
  parameter int MAX_SEG = 20,
  parameter int AW      = 32,
  parameter int LW      = 20,
  localparam int IW     = $clog2(MAX_SEG + 1),
  localparam int RW     = LW + $clog2(MAX_SEG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seg_we,
  input  logic [IW-1:0] seg_idx,
  input  logic [AW-1:0] seg_addr,
  input  logic [LW-1:0] seg_len,
  input  logic          arm,
  input  logic [IW-1:0] arm_nseg,
  input  logic          arm_cyclic,
  input  logic          prog,
  input  logic [IW-1:0] prog_cnt,
  input  logic          mid_done,
  input  logic          fin_done,
  input  logic [AW-1:0] live_pos,
  input  logic          q_valid,
  output logic          q_ready,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [RW-1:0] res_bytes
);
  logic [AW-1:0] rd_addr;
  logic [LW-1:0] rd_len;
  logic [AW-1:0] base_addr;
  logic [RW-1:0] tot_sum;
  logic [RW-1:0] bat_sum;
  logic          cyc_w;
  logic [IW-1:0] proc_w;
  logic [IW-1:0] prog_hi_w;
  logic [IW-1:0] acct_w;
  logic [RW-1:0] resid_w;
  logic [RW-1:0] stat_w;
  logic          step_w;
  logic [LW-1:0] step_len_w;

  rt_seg_table #(.MAX_SEG(MAX_SEG), .AW(AW), .LW(LW), .IW(IW), .RW(RW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(seg_we), .widx(seg_idx), .waddr(seg_addr), .wlen(seg_len),
    .ridx(acct_w), .raddr(rd_addr), .rlen(rd_len), .base_addr(base_addr),
    .tot_n(arm_nseg), .tot_sum(tot_sum),
    .bat_lo(proc_w), .bat_hi(prog_hi_w), .bat_sum(bat_sum)
  );

  rt_acct #(.MAX_SEG(MAX_SEG), .LW(LW), .IW(IW), .RW(RW)) u_acct (
    .clk(clk), .rst_n(rst_n),
    .arm(arm), .arm_nseg(arm_nseg), .arm_cyc(arm_cyclic), .arm_total(tot_sum),
    .prog(prog), .prog_cnt(prog_cnt), .bat_sum(bat_sum),
    .mid(mid_done), .fin(fin_done),
    .step(step_w), .step_len(step_len_w),
    .cyc(cyc_w), .proc(proc_w), .prog_hi(prog_hi_w), .acct(acct_w),
    .resid(resid_w), .stat(stat_w)
  );

  rt_walker #(.AW(AW), .LW(LW), .IW(IW), .RW(RW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .q_valid(q_valid), .q_ready(q_ready), .live_pos(live_pos),
    .cyc(cyc_w), .acct(acct_w), .proc(proc_w), .stat(stat_w), .resid(resid_w),
    .seg_addr(rd_addr), .seg_len(rd_len), .base_addr(base_addr),
    .step(step_w), .step_len(step_len_w),
    .res_valid(res_valid), .res_ready(res_ready), .res_bytes(res_bytes)
  );
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int IW = 5,
  parameter int RW = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          mid,
  input logic          fin,
  input logic          res_valid,
  input logic          res_ready,
  input logic [RW-1:0] res_bytes,
  input logic          cyc,
  input logic [IW-1:0] acct,
  input logic [IW-1:0] proc,
  input logic [RW-1:0] resid,
  input logic [RW-1:0] stat
);
  AST_ACCT_LE_PROC: assert property (@(posedge clk) disable iff (!rst_n)
    acct <= proc); // R1

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_bytes)); // R9

  AST_FINAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !cyc && !arm |=> resid == '0 && stat == '0); // R7

  AST_MID_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    mid && !fin && !cyc && !arm |=> acct == $past(proc) && stat == resid); // R6

  AST_RING_TOTAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cyc && !arm |=> $stable(resid)); // R8
endmodule

bind transfer_residue_tracker rt_checker #(.IW(IW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .mid(mid_done), .fin(fin_done),
  .res_valid(res_valid), .res_ready(res_ready), .res_bytes(res_bytes),
  .cyc(cyc_w), .acct(acct_w), .proc(proc_w), .resid(resid_w), .stat(stat_w)
);

// File: tb/sim_transfer_residue_tracker.sv
`timescale 1ns/1ps
module sim_transfer_residue_tracker;
  localparam int IW = 5;
  localparam int RW = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          seg_we = 1'b0;
  logic [IW-1:0] seg_idx = '0;
  logic [31:0]   seg_addr = '0;
  logic [19:0]   seg_len = '0;
  logic          arm = 1'b0;
  logic [IW-1:0] arm_nseg = '0;
  logic          arm_cyclic = 1'b0;
  logic          prog = 1'b0;
  logic [IW-1:0] prog_cnt = '0;
  logic          mid_done = 1'b0;
  logic          fin_done = 1'b0;
  logic [31:0]   live_pos = '0;
  logic          q_valid = 1'b0;
  logic          q_ready;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic [RW-1:0] res_bytes;

  always #4 clk = ~clk;

  transfer_residue_tracker u0 (
    .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_idx(seg_idx),
    .seg_addr(seg_addr), .seg_len(seg_len), .arm(arm), .arm_nseg(arm_nseg),
    .arm_cyclic(arm_cyclic), .prog(prog), .prog_cnt(prog_cnt),
    .mid_done(mid_done), .fin_done(fin_done), .live_pos(live_pos),
    .q_valid(q_valid), .q_ready(q_ready), .res_valid(res_valid),
    .res_ready(res_ready), .res_bytes(res_bytes)
  );

  int n_cmp = 0, n_bad = 0, m_cmp = 0, m_bad = 0;
  logic [RW-1:0] exp_q[$];
  string         tag_q[$];

  // monitor: compare each answer as it is handed over
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      m_cmp++;
      if (exp_q.size() == 0) begin
        m_bad++;
        $display("FAIL R9 unexpected answer actual=%0h expected=none", res_bytes);
      end else begin
        logic [RW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (res_bytes !== e) begin
          m_bad++;
          $display("FAIL %s actual=%0h expected=%0h", t, res_bytes, e);
        end
      end
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_seg(input int i, input logic [31:0] a, input logic [19:0] l);
    seg_we = 1'b1; seg_idx = IW'(i); seg_addr = a; seg_len = l;
    tick();
    seg_we = 1'b0;
  endtask

  task automatic arm_desc(input int n, input logic c);
    arm = 1'b1; arm_nseg = IW'(n); arm_cyclic = c;
    tick();
    arm = 1'b0;
  endtask

  task automatic do_prog(input int n);
    prog = 1'b1; prog_cnt = IW'(n);
    tick();
    prog = 1'b0;
  endtask

  task automatic pulse_mid();
    mid_done = 1'b1; tick(); mid_done = 1'b0;
  endtask

  task automatic pulse_fin();
    fin_done = 1'b1; tick(); fin_done = 1'b0;
  endtask

  // driver: push the expected answer, then present the query until taken
  task automatic query(input logic [31:0] p, input logic [RW-1:0] e, input string t);
    logic took;
    exp_q.push_back(e);
    tag_q.push_back(t);
    q_valid = 1'b1; live_pos = p;
    do begin
      @(negedge clk); took = q_ready;
      tick();
    end while (!took);
    q_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + m_cmp, n_bad + m_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset q_ready", 32'(q_ready), 32'd1);
    check("R1 reset res_valid", 32'(res_valid), 32'd0);

    // linear table, total 0x3D0
    load_seg(0, 32'h1000, 20'h100);
    load_seg(1, 32'h2000, 20'h080);
    load_seg(2, 32'h3000, 20'h040);
    load_seg(3, 32'h4000, 20'h200);
    load_seg(4, 32'h5000, 20'h010);
    arm_desc(5, 1'b0);
    query(32'h1010, 25'h3D0, "R2 unprogrammed total"); drain();
    do_prog(3);
    query(32'h1010, 25'h3C0, "R3 hit first segment"); drain();
    query(32'h3020, 25'h230, "R3 walk then hit"); drain();
    query(32'h3020, 25'h230, "R4 retired segments stay retired"); drain();
    query(32'h9000, 25'h210, "R5 no match returns tracked"); drain();
    pulse_mid();
    do_prog(2);
    query(32'h4100, 25'h110, "R6 after batch completion"); drain();
    // completion while walking
    query(32'h9000, 25'h000, "R10 completion during walk");
    mid_done = 1'b1; tick(); mid_done = 1'b0;
    drain();

    // back-pressure
    res_ready = 1'b0;
    query(32'h9000, 25'h000, "R9 held answer");
    repeat (3) tick();
    @(negedge clk);
    check("R9 res_valid held", 32'(res_valid), 32'd1);
    check("R9 q_ready low while busy", 32'(q_ready), 32'd0);
    check("R9 value stable", 32'(res_bytes), 32'd0);
    tick();
    res_ready = 1'b1;
    drain();

    // final completion on a re-armed list
    arm_desc(5, 1'b0);
    do_prog(5);
    query(32'h5008, 25'h008, "R4 walk to last segment"); drain();
    pulse_fin();
    query(32'h5008, 25'h000, "R7 final forces zero"); drain();

    // ring buffer, four periods of 0x100
    load_seg(0, 32'h8000, 20'h100);
    load_seg(1, 32'h8100, 20'h100);
    load_seg(2, 32'h8200, 20'h100);
    load_seg(3, 32'h8300, 20'h100);
    arm_desc(4, 1'b1);
    query(32'h8180, 25'h280, "R8 ring residue"); drain();
    pulse_mid();
    pulse_fin();
    query(32'h8180, 25'h280, "R8 completions ignored in ring"); drain();
    query(32'h8000, 25'h400, "R8 ring at start"); drain();

    repeat (4) tick();
    check("R9 scoreboard empty", 32'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + m_cmp, n_bad + m_bad);
    $finish;
  end
endmodule